// File: doc/BRIEF.md
# SDRAM Command Bus Guard

This block watches the command pins of a synchronous DRAM. It is placed beside a memory controller as a synthesizable protocol monitor, or it is used as the command front end of a behavioural memory model. On every rising clock edge it turns clock enable, chip select, the three strobes, the bank select and address bit 10 into one command. It follows the state of each bank: idle, or open with a latched row address. It keeps saturating age counters since the activates, the closes and the mode register writes that the timing rules refer to.

Any command that breaks a rule raises a one-cycle error pulse with a 4-bit code. A sticky register keeps the first error until software-free logic (a single clear input) drops it. The block also follows the data mask pin. The write mask acts in the same cycle. The read mask is delayed by two edges.

Every timing limit is a parameter, counted in clock cycles. The defaults are: 2 cycles from a mode write to the next command, 2 from activate to column command, 2 between activates, 5 from activate to precharge, 2 from close to reopen, and a burst length of 4.

Top module: `sdcmd_guard`

## Requirements
- R1: A command is taken only when chip select is low and clock enable is high at this edge and at the previous edge. Encodings of {ras_n,cas_n,we_n}: 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode write, 110 burst stop, 111 no-op. Any other cycle changes no bank and raises no error.
- R2: An activate opens bank `ba` and latches `addr` as its row. `bank_open` and `bank_row` show the new values after that edge.
- R3: A precharge with addr[10]=1 closes all banks. With addr[10]=0 it closes only bank `ba`.
- R4: A mode write or refresh while any bank is open gives code 1.
- R5: Any command other than no-op fewer than T_MRD edges after a mode write gives code 2.
- R6: A read or write to a closed bank gives code 3. A read or write to an open bank fewer than T_RCD edges after its activate gives code 4.
- R7: A read or write with addr[10]=1 starts a burst with auto-close. Any read or write on the next BURST_LEN-1 edges gives code 5. The bank closes at the last of those edges.
- R8: An activate fewer than T_RRD edges after any activate gives code 6. An activate to an already open bank gives code 7.
- R9: A precharge that closes a bank opened fewer than T_RAS edges earlier gives code 8.
- R10: An activate fewer than T_RP edges after its bank closed, by precharge or by auto-close, gives code 9.
- R11: `err_pulse` is high for exactly the cycle after the offending edge, and `err_code` then holds the code. When several rules fail together, the lowest code wins. With no error, the code is 0.
- R12: `sticky_code` keeps the first error, with `sticky_valid`, until `clr_sticky`. An error on the clearing edge is captured anew.
- R13: `wr_mask` follows `dqm` in the same cycle. `rd_hiz` equals the `dqm` value sampled two edges earlier. Both ignore chip select.
- R14: Read and write commands to open, settled banks may follow each other on every edge with no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| ba | input | 2 | Bank select |
| addr | input | 13 | Multiplexed address; bit 10 is the all-bank / auto-close flag |
| dqm | input | 1 | Data mask pin |
| clr_sticky | input | 1 | Clears the sticky error record |
| err_pulse | output | 1 | One-cycle violation flag |
| err_code | output | 4 | Code of the violated rule, 0 when none |
| sticky_valid | output | 1 | A first error is held |
| sticky_code | output | 4 | Code of the first error |
| bank_open | output | 4 | Per-bank open flag |
| bank_row | output | 52 | Open row per bank, bank b at bits [13b+12:13b] |
| wr_mask | output | 1 | Write data masked this cycle |
| rd_hiz | output | 1 | Read data driven high impedance this cycle |

## Verification
The main stream is a sequence of bus commands. Each command is placed at a chosen distance after the one it depends on. A vector just inside a limit and one just outside it show whether each counter starts at the right edge. Vectors where two rules fail at once show the priority order. A deselected cycle with strobe bits that would otherwise be an illegal mode write shows that chip select really gates the decode. Directed steps then cover a clock-enable low cycle, single-bank precharge against all-bank precharge, the sticky clear, and a mask bit pattern whose shifted copy shows the two-edge read latency apart from the zero-latency write mask.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

  typedef enum logic [2:0] {
    C_NOP, C_ACT, C_RD, C_WR, C_PRE, C_REF, C_MRS, C_BST
  } cmd_e;

  typedef enum logic [3:0] {
    E_NONE      = 4'd0,
    E_MODE_BUSY = 4'd1,
    E_MODE_GAP  = 4'd2,
    E_COL_IDLE  = 4'd3,
    E_COL_EARLY = 4'd4,
    E_COL_IN_AP = 4'd5,
    E_ACT_SPACE = 4'd6,
    E_ACT_OPEN  = 4'd7,
    E_PRE_EARLY = 4'd8,
    E_ACT_RP    = 4'd9
  } err_e;

  function automatic cmd_e pin_cmd(input logic ras_n, input logic cas_n, input logic we_n);
    cmd_e c;
    case ({ras_n, cas_n, we_n})
      3'b011:  c = C_ACT;
      3'b101:  c = C_RD;
      3'b100:  c = C_WR;
      3'b010:  c = C_PRE;
      3'b001:  c = C_REF;
      3'b000:  c = C_MRS;
      3'b110:  c = C_BST;
      default: c = C_NOP;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/sdcmd_decode.sv
module sdcmd_decode
  import sdcmd_pkg::*;
#(
  parameter int BA_W  = 2,
  parameter int ROW_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke,
  input  logic             cs_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic [BA_W-1:0]  ba,
  input  logic [ROW_W-1:0] addr,
  output cmd_e             cmd,
  output logic [BA_W-1:0]  cmd_ba,
  output logic             cmd_flag,
  output logic [ROW_W-1:0] cmd_row
);

  logic cke_q, cke_d;

  always_comb cke_d = cke;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cke_q <= 1'b0;
    else        cke_q <= cke_d;
  end

  // clock enable must be high at this edge and at the one before
  always_comb begin
    if (cke && cke_q && !cs_n) cmd = pin_cmd(ras_n, cas_n, we_n);
    else                       cmd = C_NOP;
  end

  assign cmd_ba   = ba;
  assign cmd_flag = addr[10];
  assign cmd_row  = addr;

endmodule

// File: rtl/sdcmd_bank.sv
module sdcmd_bank #(
  parameter int ROW_W   = 13,
  parameter int AGE_W   = 3,
  parameter int AGE_MAX = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_evt,
  input  logic             close_evt,
  input  logic [ROW_W-1:0] row_in,
  output logic             is_open,
  output logic [ROW_W-1:0] row,
  output logic [AGE_W-1:0] act_age,
  output logic [AGE_W-1:0] idle_age
);

  localparam logic [AGE_W-1:0] SAT = AGE_W'(AGE_MAX);
  localparam logic [AGE_W-1:0] ONE = AGE_W'(1);

  logic             open_q, open_d;
  logic [ROW_W-1:0] row_q;
  logic             row_en;
  logic [AGE_W-1:0] act_q, act_d, idle_q, idle_d;

  always_comb begin
    open_d = open_q;
    if (open_evt)       open_d = 1'b1;
    else if (close_evt) open_d = 1'b0;
    row_en = open_evt;
    if (open_evt)         act_d = ONE;
    else if (act_q < SAT) act_d = act_q + ONE;
    else                  act_d = act_q;
    // the close age restarts only when an open bank really closes
    if (close_evt && open_q && !open_evt) idle_d = ONE;
    else if (idle_q < SAT)                idle_d = idle_q + ONE;
    else                                  idle_d = idle_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      act_q  <= SAT;
      idle_q <= SAT;
    end else begin
      open_q <= open_d;
      act_q  <= act_d;
      idle_q <= idle_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      row_q <= '0;
    else if (row_en) row_q <= row_in;
  end

  assign is_open  = open_q;
  assign row      = row_q;
  assign act_age  = act_q;
  assign idle_age = idle_q;

endmodule

// File: rtl/sdcmd_rules.sv
module sdcmd_rules
  import sdcmd_pkg::*;
#(
  parameter int BA_W  = 2,
  parameter int AGE_W = 3,
  parameter int T_MRD = 2,
  parameter int T_RCD = 2,
  parameter int T_RRD = 2,
  parameter int T_RAS = 5,
  parameter int T_RP  = 2
) (
  input  cmd_e                    cmd,
  input  logic [BA_W-1:0]         ba,
  input  logic                    flag,
  input  logic [(1<<BA_W)-1:0]    bank_open,
  input  logic [(1<<BA_W)*AGE_W-1:0] act_age,
  input  logic [(1<<BA_W)*AGE_W-1:0] idle_age,
  input  logic [AGE_W-1:0]        rrd_age,
  input  logic [AGE_W-1:0]        mrd_age,
  input  logic                    ap_busy,
  output err_e                    code
);

  localparam int NBANK = 1 << BA_W;
  localparam logic [AGE_W-1:0] MRD_L = AGE_W'(T_MRD);
  localparam logic [AGE_W-1:0] RCD_L = AGE_W'(T_RCD);
  localparam logic [AGE_W-1:0] RRD_L = AGE_W'(T_RRD);
  localparam logic [AGE_W-1:0] RAS_L = AGE_W'(T_RAS);
  localparam logic [AGE_W-1:0] RP_L  = AGE_W'(T_RP);

  logic [AGE_W-1:0] act_a  [NBANK];
  logic [AGE_W-1:0] idle_a [NBANK];
  logic [NBANK-1:0] young;

  for (genvar b = 0; b < NBANK; b++) begin : g_split
    assign act_a[b]  = act_age[b*AGE_W +: AGE_W];
    assign idle_a[b] = idle_age[b*AGE_W +: AGE_W];
    assign young[b]  = bank_open[b] && (act_a[b] < RAS_L);
  end

  logic is_col, is_act, is_pre, is_mode;
  logic sel_open;

  always_comb begin
    is_col   = (cmd == C_RD) || (cmd == C_WR);
    is_act   = (cmd == C_ACT);
    is_pre   = (cmd == C_PRE);
    is_mode  = (cmd == C_MRS) || (cmd == C_REF);
    sel_open = bank_open[ba];
    // lowest code has priority
    if (is_mode && (|bank_open))                    code = E_MODE_BUSY;
    else if ((cmd != C_NOP) && (mrd_age < MRD_L))   code = E_MODE_GAP;
    else if (is_col && !sel_open)                   code = E_COL_IDLE;
    else if (is_col && (act_a[ba] < RCD_L))         code = E_COL_EARLY;
    else if (is_col && ap_busy)                     code = E_COL_IN_AP;
    else if (is_act && (rrd_age < RRD_L))           code = E_ACT_SPACE;
    else if (is_act && sel_open)                    code = E_ACT_OPEN;
    else if (is_pre && (flag ? (|young) : young[ba])) code = E_PRE_EARLY;
    else if (is_act && (idle_a[ba] < RP_L))         code = E_ACT_RP;
    else                                            code = E_NONE;
  end

endmodule

// File: rtl/sdcmd_flag.sv
module sdcmd_flag
  import sdcmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  err_e       code,
  input  logic       clr,
  output logic       err_pulse,
  output logic [3:0] err_code,
  output logic       sticky_valid,
  output logic [3:0] sticky_code
);

  logic       pulse_q, pulse_d;
  logic [3:0] code_q, code_d;
  logic       sv_q, sv_d;
  logic [3:0] sc_q, sc_d;

  always_comb begin
    pulse_d = (code != E_NONE);
    code_d  = code;
    sv_d    = sv_q;
    sc_d    = sc_q;
    if (pulse_d && (!sv_q || clr)) begin
      sv_d = 1'b1;
      sc_d = code;
    end else if (clr) begin
      sv_d = 1'b0;
      sc_d = 4'd0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      code_q  <= 4'd0;
      sv_q    <= 1'b0;
      sc_q    <= 4'd0;
    end else begin
      pulse_q <= pulse_d;
      code_q  <= code_d;
      sv_q    <= sv_d;
      sc_q    <= sc_d;
    end
  end

  assign err_pulse    = pulse_q;
  assign err_code     = code_q;
  assign sticky_valid = sv_q;
  assign sticky_code  = sc_q;

endmodule

// File: rtl/sdcmd_guard.sv
module sdcmd_guard
  import sdcmd_pkg::*;
#(
  parameter int BA_W        = 2,
  parameter int ROW_W       = 13,
  parameter int T_MRD       = 2,
  parameter int T_RCD       = 2,
  parameter int T_RRD       = 2,
  parameter int T_RAS       = 5,
  parameter int T_RP        = 2,
  parameter int BURST_LEN   = 4,
  parameter int RD_MASK_LAT = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cke,
  input  logic                          cs_n,
  input  logic                          ras_n,
  input  logic                          cas_n,
  input  logic                          we_n,
  input  logic [BA_W-1:0]               ba,
  input  logic [ROW_W-1:0]              addr,
  input  logic                          dqm,
  input  logic                          clr_sticky,
  output logic                          err_pulse,
  output logic [3:0]                    err_code,
  output logic                          sticky_valid,
  output logic [3:0]                    sticky_code,
  output logic [(1<<BA_W)-1:0]          bank_open,
  output logic [(1<<BA_W)*ROW_W-1:0]    bank_row,
  output logic                          wr_mask,
  output logic                          rd_hiz
);

  localparam int NBANK   = 1 << BA_W;
  localparam int M1      = (T_MRD > T_RCD) ? T_MRD : T_RCD;
  localparam int M2      = (T_RRD > T_RP) ? T_RRD : T_RP;
  localparam int M3      = (M1 > M2) ? M1 : M2;
  localparam int AGE_MAX = (M3 > T_RAS) ? M3 : T_RAS;
  localparam int AGE_W   = $clog2(AGE_MAX + 1);
  localparam int BL_W    = $clog2(BURST_LEN + 1);
  localparam logic [AGE_W-1:0] SAT  = AGE_W'(AGE_MAX);
  localparam logic [AGE_W-1:0] ONE  = AGE_W'(1);
  localparam logic [BL_W-1:0]  BL_M1 = BL_W'(BURST_LEN - 1);
  localparam logic [BL_W-1:0]  BL_1  = BL_W'(1);

  // ---------------- decode
  cmd_e             cmd;
  logic [BA_W-1:0]  cmd_ba;
  logic             cmd_flag;
  logic [ROW_W-1:0] cmd_row;

  sdcmd_decode #(.BA_W(BA_W), .ROW_W(ROW_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
    .cmd(cmd), .cmd_ba(cmd_ba), .cmd_flag(cmd_flag), .cmd_row(cmd_row)
  );

  // ---------------- auto-close burst tracker and global ages
  logic [BL_W-1:0]  ap_left_q, ap_left_d;
  logic [BA_W-1:0]  ap_bank_q, ap_bank_d;
  logic             ap_arm, ap_busy;
  logic [AGE_W-1:0] rrd_q, rrd_d, mrd_q, mrd_d;

  always_comb begin
    ap_arm    = ((cmd == C_RD) || (cmd == C_WR)) && cmd_flag;
    ap_busy   = (ap_left_q != '0);
    ap_left_d = ap_left_q;
    ap_bank_d = ap_bank_q;
    if (ap_arm) begin
      ap_left_d = BL_M1;
      ap_bank_d = cmd_ba;
    end else if (ap_busy) begin
      ap_left_d = ap_left_q - BL_1;
    end
    if (cmd == C_ACT)    rrd_d = ONE;
    else if (rrd_q < SAT) rrd_d = rrd_q + ONE;
    else                  rrd_d = rrd_q;
    if (cmd == C_MRS)    mrd_d = ONE;
    else if (mrd_q < SAT) mrd_d = mrd_q + ONE;
    else                  mrd_d = mrd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ap_left_q <= '0;
      ap_bank_q <= '0;
      rrd_q     <= SAT;
      mrd_q     <= SAT;
    end else begin
      ap_left_q <= ap_left_d;
      ap_bank_q <= ap_bank_d;
      rrd_q     <= rrd_d;
      mrd_q     <= mrd_d;
    end
  end

  // ---------------- banks
  logic [NBANK*AGE_W-1:0] act_age_v, idle_age_v;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic open_evt, close_evt, ap_close;
    logic [ROW_W-1:0] row_b;
    if (BURST_LEN == 1) begin : g_bl1
      assign ap_close = ap_arm && (cmd_ba == BA_W'(b));
    end else begin : g_bln
      assign ap_close = (ap_left_q == BL_1) && (ap_bank_q == BA_W'(b));
    end
    assign open_evt  = (cmd == C_ACT) && (cmd_ba == BA_W'(b));
    assign close_evt = ((cmd == C_PRE) && (cmd_flag || (cmd_ba == BA_W'(b)))) || ap_close;

    sdcmd_bank #(.ROW_W(ROW_W), .AGE_W(AGE_W), .AGE_MAX(AGE_MAX)) u_bank (
      .clk(clk), .rst_n(rst_n), .open_evt(open_evt), .close_evt(close_evt),
      .row_in(cmd_row), .is_open(bank_open[b]), .row(row_b),
      .act_age(act_age_v[b*AGE_W +: AGE_W]), .idle_age(idle_age_v[b*AGE_W +: AGE_W])
    );
    assign bank_row[b*ROW_W +: ROW_W] = row_b;
  end

  // ---------------- rules and error record
  err_e code;

  sdcmd_rules #(
    .BA_W(BA_W), .AGE_W(AGE_W), .T_MRD(T_MRD), .T_RCD(T_RCD),
    .T_RRD(T_RRD), .T_RAS(T_RAS), .T_RP(T_RP)
  ) u_rules (
    .cmd(cmd), .ba(cmd_ba), .flag(cmd_flag), .bank_open(bank_open),
    .act_age(act_age_v), .idle_age(idle_age_v), .rrd_age(rrd_q),
    .mrd_age(mrd_q), .ap_busy(ap_busy), .code(code)
  );

  sdcmd_flag u_flag (
    .clk(clk), .rst_n(rst_n), .code(code), .clr(clr_sticky),
    .err_pulse(err_pulse), .err_code(err_code),
    .sticky_valid(sticky_valid), .sticky_code(sticky_code)
  );

  // ---------------- data mask: zero latency on writes, delayed on reads
  logic [RD_MASK_LAT-1:0] mask_q, mask_d;

  always_comb begin
    mask_d[0] = dqm;
    for (int i = 1; i < RD_MASK_LAT; i++) mask_d[i] = mask_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  assign wr_mask = dqm;
  assign rd_hiz  = mask_q[RD_MASK_LAT-1];

endmodule

// File: rtl/sdcmd_guard_chk.sv
module sdcmd_guard_chk #(
  parameter int BA_W = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cke,
  input logic                 cs_n,
  input logic                 ras_n,
  input logic                 cas_n,
  input logic                 we_n,
  input logic [BA_W-1:0]      ba,
  input logic                 addr10,
  input logic                 dqm,
  input logic                 clr_sticky,
  input logic                 err_pulse,
  input logic [3:0]           err_code,
  input logic                 sticky_valid,
  input logic [3:0]           sticky_code,
  input logic [(1<<BA_W)-1:0] bank_open,
  input logic                 rd_hiz
);

  logic       cke_prev;
  logic [1:0] cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_prev <= 1'b0;
      cyc      <= 2'd0;
    end else begin
      cke_prev <= cke;
      if (cyc != 2'd3) cyc <= cyc + 2'd1;
    end
  end

  logic live, v_act, v_pre, v_mode;
  assign live   = cke && cke_prev && !cs_n;
  assign v_act  = live && ({ras_n, cas_n, we_n} == 3'b011);
  assign v_pre  = live && ({ras_n, cas_n, we_n} == 3'b010);
  assign v_mode = live && (({ras_n, cas_n, we_n} == 3'b000) || ({ras_n, cas_n, we_n} == 3'b001));

  p_quiet_when_deselected_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || !cke) |=> !err_pulse);

  p_act_opens_bank_r2: assert property (@(posedge clk) disable iff (!rst_n)
    v_act |=> bank_open[$past(ba)]);

  p_all_close_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (v_pre && addr10) |=> (bank_open == '0));

  p_mode_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (v_mode && (|bank_open)) |=> (err_pulse && err_code == 4'd1));

  p_pulse_has_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> (err_code != 4'd0));

  p_no_pulse_no_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !err_pulse |-> (err_code == 4'd0));

  p_sticky_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky_valid && !clr_sticky) |=> (sticky_valid && $stable(sticky_code)));

  p_read_mask_delay_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd3) |-> (rd_hiz == $past(dqm, 2)));

endmodule

bind sdcmd_guard sdcmd_guard_chk #(.BA_W(BA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
  .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr10(addr[10]), .dqm(dqm),
  .clr_sticky(clr_sticky), .err_pulse(err_pulse), .err_code(err_code),
  .sticky_valid(sticky_valid), .sticky_code(sticky_code),
  .bank_open(bank_open), .rd_hiz(rd_hiz)
);

// File: tb/sim_sdcmd_guard.sv
module sim_sdcmd_guard;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cke = 1'b1;
  logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  ba = 2'd0;
  logic [12:0] addr = 13'd0;
  logic        dqm = 1'b0;
  logic        clr_sticky = 1'b0;
  logic        err_pulse, sticky_valid, wr_mask, rd_hiz;
  logic [3:0]  err_code, sticky_code, bank_open;
  logic [51:0] bank_row;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sdcmd_guard u0 (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .dqm(dqm),
    .clr_sticky(clr_sticky), .err_pulse(err_pulse), .err_code(err_code),
    .sticky_valid(sticky_valid), .sticky_code(sticky_code),
    .bank_open(bank_open), .bank_row(bank_row), .wr_mask(wr_mask), .rd_hiz(rd_hiz)
  );

  localparam logic [3:0] K_NOP = 4'b0111, K_ACT = 4'b0011, K_RD = 4'b0101,
                         K_WR = 4'b0100, K_PRE = 4'b0010, K_REF = 4'b0001,
                         K_MRS = 4'b0000, K_DES = 4'b1000;

  // {cs,ras,cas,we}[14:11] ba[10:9] a10[8] expected code[7:4] requirement no.[3:0]
  localparam int NV = 26;
  localparam logic [14:0] VEC [NV] = '{
    {K_NOP, 2'd0, 1'b0, 4'd0, 4'd1},   // R1 first edge
    {K_ACT, 2'd0, 1'b0, 4'd0, 4'd2},   // R2 open bank 0
    {K_RD,  2'd0, 1'b0, 4'd4, 4'd6},   // R6 column one edge after activate
    {K_RD,  2'd0, 1'b0, 4'd0, 4'd6},   // R6 two edges: allowed
    {K_ACT, 2'd1, 1'b0, 4'd0, 4'd8},   // R8 spacing 3
    {K_ACT, 2'd2, 1'b0, 4'd6, 4'd8},   // R8 spacing 1
    {K_WR,  2'd1, 1'b0, 4'd0, 4'd14},  // R14
    {K_WR,  2'd0, 1'b0, 4'd0, 4'd14},  // R14 back to back
    {K_PRE, 2'd1, 1'b0, 4'd8, 4'd9},   // R9 open only 4 edges
    {K_ACT, 2'd1, 1'b0, 4'd9, 4'd10},  // R10 reopen one edge after close
    {K_ACT, 2'd1, 1'b0, 4'd6, 4'd11},  // R11 codes 6 and 7 together, 6 wins
    {K_NOP, 2'd0, 1'b0, 4'd0, 4'd1},   // R1
    {K_RD,  2'd3, 1'b0, 4'd3, 4'd6},   // R6 closed bank
    {K_MRS, 2'd0, 1'b0, 4'd1, 4'd4},   // R4 banks open
    {K_RD,  2'd0, 1'b1, 4'd2, 4'd5},   // R5 right after mode write; arms auto-close
    {K_NOP, 2'd0, 1'b0, 4'd0, 4'd7},   // R7
    {K_WR,  2'd2, 1'b0, 4'd5, 4'd7},   // R7 column inside burst
    {K_NOP, 2'd0, 1'b0, 4'd0, 4'd7},   // R7 bank 0 closes here
    {K_ACT, 2'd0, 1'b0, 4'd9, 4'd10},  // R10 after auto-close
    {K_PRE, 2'd0, 1'b1, 4'd8, 4'd3},   // R3 all-bank close, bank 0 young (R9)
    {K_REF, 2'd0, 1'b0, 4'd0, 4'd4},   // R4 all idle
    {K_NOP, 2'd0, 1'b0, 4'd0, 4'd1},   // R1
    {K_MRS, 2'd0, 1'b0, 4'd0, 4'd4},   // R4 all idle
    {K_NOP, 2'd0, 1'b0, 4'd0, 4'd5},   // R5 no-op exempt
    {K_ACT, 2'd3, 1'b0, 4'd0, 4'd5},   // R5 two edges after mode write
    {K_DES, 2'd3, 1'b0, 4'd0, 4'd1}    // R1 deselected, strobes all low
  };

  function automatic logic [12:0] row_of(input int i, input logic a10);
    logic [12:0] r;
    r = 13'((i * 613 + 97) % 8192);
    r[10] = a10;
    return r;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] pins, input logic [1:0] b, input logic [12:0] a);
    {cs_n, ras_n, cas_n, we_n} = pins;
    ba = b;
    addr = a;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // reset state
    chk("R2 reset bank_open", int'(bank_open), 0);
    chk("R11 reset err_pulse", int'(err_pulse), 0);
    chk("R12 reset sticky_valid", int'(sticky_valid), 0);
    rst_n = 1'b1;

    // table walk: one vector per edge, result checked one negedge later
    for (int i = 0; i <= NV; i++) begin
      @(negedge clk);
      if (i > 0) begin
        chk($sformatf("R%0d vec%0d err_code", VEC[i-1][3:0], i-1), int'(err_code), int'(VEC[i-1][7:4]));
        chk($sformatf("R11 vec%0d err_pulse", i-1), int'(err_pulse), int'(VEC[i-1][7:4] != 4'd0));
      end
      if (i < NV) drive(VEC[i][14:11], VEC[i][10:9], row_of(i, VEC[i][8]));
      else        drive(K_NOP, 2'd0, 13'd0);
    end

    chk("R2 row of bank 3", int'(bank_row[39 +: 13]), int'(row_of(24, 1'b0)));
    chk("R3 only bank 3 open", int'(bank_open), 8);
    chk("R12 sticky first code", int'(sticky_code), 4);
    chk("R12 sticky valid", int'(sticky_valid), 1);

    // clear
    clr_sticky = 1'b1;
    @(negedge clk);
    clr_sticky = 1'b0;
    chk("R12 cleared", int'(sticky_valid), 0);

    // clock enable low one cycle: the activate that follows is ignored
    cke = 1'b0;
    @(negedge clk);
    cke = 1'b1;
    drive(K_ACT, 2'd2, 13'h0ABC);
    @(negedge clk);
    chk("R1 activate after low enable ignored", int'(bank_open[2]), 0);
    chk("R1 no error on ignored cycle", int'(err_pulse), 0);
    @(negedge clk);
    chk("R2 activate opens bank 2", int'(bank_open[2]), 1);
    chk("R2 row of bank 2", int'(bank_row[26 +: 13]), 13'h0ABC);
    drive(K_PRE, 2'd2, 13'd0);
    @(negedge clk);
    chk("R9 young single precharge", int'(err_code), 8);
    chk("R3 single precharge closes only bank 2", int'(bank_open), 8);
    chk("R12 new first error after clear", int'(sticky_code), 8);
    drive(K_NOP, 2'd0, 13'd0);

    // mask pattern on deselected cycles
    begin
      logic [7:0] pat = 8'b1011_0010;
      drive(K_DES, 2'd0, 13'd0);
      for (int j = 0; j < 8; j++) begin
        @(negedge clk);
        if (j >= 2) chk($sformatf("R13 read mask step %0d", j), int'(rd_hiz), int'(pat[j-2]));
        dqm = pat[j];
        #1;
        chk($sformatf("R13 write mask step %0d", j), int'(wr_mask), int'(pat[j]));
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule